// File: doc/BRIEF.md
# Programmable CPU Address Decode Window Map

This block turns a 32-bit CPU address into a target port choice by comparing it with a set of decode windows that software programs. Each window covers a power-of-two region with 64 KB granularity. A window carries a target port ID, an 8-bit attribute byte for the downstream port, and an enable bit. Only the lowest-numbered windows can also remap: for them, the address bits inside the window are kept and the bits above them come from a remap register. All other windows pass the address through unchanged.

Software reads and writes the window registers through a plain 32-bit register port. Every window owns a 16-byte group, and the group for window n starts at byte offset n*16. The lookup path is purely combinational. If several windows hit, the lowest-numbered one wins. If no window hits, the block reports a miss.

Top module: `xlat_window_map`

## Requirements
- R1: After reset every register reads zero and no lookup address hits.
- R2: Register offsets are window*16 + slot*4, with slot 0 control, 1 base, 2 remap-low and 3 remap-high; reg_addr[1:0] is ignored. The control word reads back with the size mask (size-1) in bits 31:16, the attribute in bits 15:8, the target ID in bits 7:4 and the enable in bit 0, and bits 3:1 read zero.
- R3: The base and remap-low registers keep only bits 31:16, and bits 15:0 read zero.
- R4: For windows at or above NUM_REMAP, the remap-low and remap-high slots read zero and ignore writes, and their lookups are never translated.
- R5: An enabled window hits when (addr[31:16] & ~mask) equals (base[31:16] & ~mask), including at both ends of its region.
- R6: A window whose enable bit is 0 never hits.
- R7: When several windows hit, the lowest-numbered one supplies the target, the attribute and the translation.
- R8: On a miss, dec_hit is 0, dec_tgt and dec_attr are 0, and dec_addr equals lookup_addr.
- R9: A remap-capable window outputs {(remap[31:16] & ~mask) | (addr[31:16] & mask), addr[15:0]}. Other windows output the address unchanged. Target codes: 0 DRAM, 1 device bus, 3 PCI, 4 PCIe.
- R10: The lookup outputs are combinational from lookup_addr. A register write changes the lookup only after the clock edge that captures it.
- R11: The remap-high register of a remap-capable window stores and reads back all 32 bits and does not affect the translated 32-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the register at reg_addr |
| lookup_addr | input | 32 | CPU address to decode |
| dec_hit | output | 1 | Some enabled window matched (low means miss) |
| dec_tgt | output | 4 | Target ID of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_addr | output | 32 | Translated address |

## Verification
Lookup results and readback data appear in the same cycle as their inputs. The bench therefore drives lookup_addr or reg_addr just after a falling edge and samples one time unit later, with no clock edge in between. A register write becomes visible only after the next rising edge. Each write is held across exactly one rising edge, and its effect is checked after the following falling edge. The write-timing test samples the lookup once before that edge and once after it.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W = 32;
    localparam int HI_W   = 16;

    typedef enum logic [3:0] {
        TGT_DRAM   = 4'd0,
        TGT_DEVBUS = 4'd1,
        TGT_PCI    = 4'd3,
        TGT_PCIE   = 4'd4
    } tgt_e;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_BASE   = 2'd1,
        SLOT_RMP_LO = 2'd2,
        SLOT_RMP_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic [HI_W-1:0] mask;
        logic [7:0]      attr;
        logic [3:0]      tgt;
        logic            en;
    } win_ctrl_t;

    typedef struct packed {
        win_ctrl_t         ctrl;
        logic [HI_W-1:0]   base;
        logic [HI_W-1:0]   rmp_lo;
        logic [ADDR_W-1:0] rmp_hi;
    } win_regs_t;

    typedef struct packed {
        logic              hit;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [ADDR_W-1:0] xaddr;
    } dec_res_t;

    function automatic logic [ADDR_W-1:0] pack_ctrl(win_ctrl_t c);
        return {c.mask, c.attr, c.tgt, 3'b000, c.en};
    endfunction

    function automatic win_ctrl_t unpack_ctrl(logic [ADDR_W-1:0] w);
        win_ctrl_t c;
        c.mask = w[31:16];
        c.attr = w[15:8];
        c.tgt  = w[7:4];
        c.en   = w[0];
        return c;
    endfunction

    function automatic logic win_hit(logic en, logic [HI_W-1:0] mask,
                                     logic [HI_W-1:0] base,
                                     logic [ADDR_W-1:0] a);
        return en && ((a[31:16] & ~mask) == (base & ~mask));
    endfunction

    function automatic logic [ADDR_W-1:0] win_xlat(logic [HI_W-1:0] mask,
                                                   logic [HI_W-1:0] rmp,
                                                   logic [ADDR_W-1:0] a);
        return {(rmp & ~mask) | (a[31:16] & mask), a[15:0]};
    endfunction

endpackage

// File: rtl/xlat_win_regfile.sv
module xlat_win_regfile
    import xlat_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int SEL_W    = IDX_W + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          sel,
    input  logic [ADDR_W-1:0]         wdata,
    output logic [ADDR_W-1:0]         rdata,
    output win_regs_t [NUM_WIN-1:0]   regs
);

    logic [IDX_W-1:0] win_sel;
    slot_e            slot;

    assign win_sel = sel[SEL_W-1:2];
    assign slot    = slot_e'(sel[1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic      wr_here;
        win_ctrl_t ctrl_q;
        logic [HI_W-1:0] base_q;

        assign wr_here = wr_en && (win_sel == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= '0;
                base_q <= '0;
            end else if (wr_here) begin
                if (slot == SLOT_CTRL) ctrl_q <= unpack_ctrl(wdata);
                if (slot == SLOT_BASE) base_q <= wdata[31:16];
            end
        end

        assign regs[w].ctrl = ctrl_q;
        assign regs[w].base = base_q;

        if (w < NUM_REMAP) begin : g_rmp
            logic [HI_W-1:0]   rmp_lo_q;
            logic [ADDR_W-1:0] rmp_hi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rmp_lo_q <= '0;
                    rmp_hi_q <= '0;
                end else if (wr_here) begin
                    if (slot == SLOT_RMP_LO) rmp_lo_q <= wdata[31:16];
                    if (slot == SLOT_RMP_HI) rmp_hi_q <= wdata;
                end
            end
            assign regs[w].rmp_lo = rmp_lo_q;
            assign regs[w].rmp_hi = rmp_hi_q;
        end else begin : g_normp
            assign regs[w].rmp_lo = '0;
            assign regs[w].rmp_hi = '0;
        end
    end

    always_comb begin
        rdata = '0;
        case (slot)
            SLOT_CTRL:   rdata = pack_ctrl(regs[win_sel].ctrl);
            SLOT_BASE:   rdata = {regs[win_sel].base, 16'h0000};
            SLOT_RMP_LO: rdata = {regs[win_sel].rmp_lo, 16'h0000};
            SLOT_RMP_HI: rdata = regs[win_sel].rmp_hi;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/xlat_win_slot.sv
module xlat_win_slot
    import xlat_pkg::*;
#(
    parameter bit CAN_REMAP = 1'b0
) (
    input  logic              en,
    input  logic [HI_W-1:0]   mask,
    input  logic [HI_W-1:0]   base,
    input  logic [HI_W-1:0]   rmp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    assign hit = win_hit(en, mask, base, addr);

    if (CAN_REMAP) begin : g_remap
        assign xaddr = win_xlat(mask, rmp, addr);
    end else begin : g_pass
        logic unused_rmp;
        assign unused_rmp = ^rmp;
        assign xaddr = addr;
    end

endmodule

// File: rtl/xlat_prio_sel.sv
module xlat_prio_sel
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0]              hits,
    input  win_ctrl_t [NUM_WIN-1:0]         ctrls,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xaddrs,
    input  logic [ADDR_W-1:0]               addr,
    output dec_res_t                        res
);

    always_comb begin
        res.hit   = 1'b0;
        res.tgt   = '0;
        res.attr  = '0;
        res.xaddr = addr;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                res.hit   = 1'b1;
                res.tgt   = ctrls[i].tgt;
                res.attr  = ctrls[i].attr;
                res.xaddr = xaddrs[i];
            end
        end
    end

endmodule

// File: rtl/xlat_window_map.sv
module xlat_window_map
    import xlat_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int REG_AW   = $clog2(NUM_WIN) + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       lookup_addr,
    output logic              dec_hit,
    output logic [3:0]        dec_tgt,
    output logic [7:0]        dec_attr,
    output logic [31:0]       dec_addr
);

    win_regs_t [NUM_WIN-1:0]             regs;
    win_ctrl_t [NUM_WIN-1:0]             ctrls;
    logic [NUM_WIN-1:0]                  hits;
    logic [NUM_WIN-1:0][ADDR_W-1:0]      xaddrs;
    dec_res_t                            res;
    logic                                unused_byte_off;

    assign unused_byte_off = ^reg_addr[1:0];

    xlat_win_regfile #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .sel   (reg_addr[REG_AW-1:2]),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (regs)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        assign ctrls[w] = regs[w].ctrl;
        xlat_win_slot #(
            .CAN_REMAP (w < NUM_REMAP)
        ) u_slot (
            .en    (regs[w].ctrl.en),
            .mask  (regs[w].ctrl.mask),
            .base  (regs[w].base),
            .rmp   (regs[w].rmp_lo),
            .addr  (lookup_addr),
            .hit   (hits[w]),
            .xaddr (xaddrs[w])
        );
    end

    xlat_prio_sel #(
        .NUM_WIN (NUM_WIN)
    ) u_sel (
        .hits   (hits),
        .ctrls  (ctrls),
        .xaddrs (xaddrs),
        .addr   (lookup_addr),
        .res    (res)
    );

    assign dec_hit  = res.hit;
    assign dec_tgt  = res.tgt;
    assign dec_attr = res.attr;
    assign dec_addr = res.xaddr;

endmodule

// File: rtl/xlat_window_map_chk.sv
module xlat_window_map_chk #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int REG_AW   = $clog2(NUM_WIN) + 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [31:0]       lookup_addr,
    input logic              dec_hit,
    input logic [3:0]        dec_tgt,
    input logic [7:0]        dec_attr,
    input logic [31:0]       dec_addr
);

    assert_miss_clean_R8: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_tgt == 4'h0 && dec_attr == 8'h00 && dec_addr == lookup_addr));

    assert_low_bits_kept_R9: assert property (@(posedge clk) disable iff (rst)
        dec_addr[15:0] == lookup_addr[15:0]);

    assert_remap_absent_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_addr[REG_AW-1:4]) >= NUM_REMAP && reg_addr[3]) |-> reg_rdata == 32'h0);

    assert_ctrl_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[3:2] == 2'd0) |-> reg_rdata[3:1] == 3'b000);

    assert_base_gran_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[3:2] == 2'd1) |-> reg_rdata[15:0] == 16'h0000);

    assert_write_next_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr_en) && $past(reg_addr[3:2]) == 2'd1
         && reg_addr == $past(reg_addr))
        |-> reg_rdata == ($past(reg_wdata) & 32'hFFFF_0000));

endmodule

bind xlat_window_map xlat_window_map_chk #(
    .NUM_WIN   (NUM_WIN),
    .NUM_REMAP (NUM_REMAP)
) u_chk (.*);

// File: tb/sim_xlat_window_map.sv
module sim_xlat_window_map;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lookup_addr = '0;
    logic        dec_hit;
    logic [3:0]  dec_tgt;
    logic [7:0]  dec_attr;
    logic [31:0] dec_addr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_window_map #(.NUM_WIN(8), .NUM_REMAP(2)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_addr(lookup_addr),
        .dec_hit(dec_hit), .dec_tgt(dec_tgt), .dec_attr(dec_attr), .dec_addr(dec_addr)
    );

    localparam logic [31:0] V_ADDR [NV] = '{
        32'h9001_2345, 32'h900F_FFFF, 32'h9010_0000, 32'h98AB_CDEF, 32'h98FF_FFFF,
        32'h9900_0000, 32'hE123_4567, 32'hF000_0010, 32'hFF12_0004, 32'h0000_1000};
    localparam logic V_HIT [NV] = '{1, 1, 1, 1, 1, 0, 1, 0, 1, 0};
    localparam logic [3:0] V_TGT [NV] = '{4, 4, 3, 3, 3, 0, 4, 0, 1, 0};
    localparam logic [7:0] V_ATTR [NV] = '{
        8'h51, 8'h51, 8'h59, 8'h51, 8'h51, 8'h00, 8'h59, 8'h00, 8'h1E, 8'h00};
    localparam logic [31:0] V_XLAT [NV] = '{
        32'h4001_2345, 32'h400F_FFFF, 32'h9010_0000, 32'h12AB_CDEF, 32'h12FF_FFFF,
        32'h9900_0000, 32'hE123_4567, 32'hF000_0010, 32'hFF12_0004, 32'h0000_1000};
    localparam string V_REQ [NV] = '{
        "R7/R9", "R5/R9", "R5/R9", "R9/R11", "R5", "R8", "R4/R9", "R6", "R9", "R8"};

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [6:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s read @%02h: got %08h expected %08h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_lk(input logic [31:0] a, input logic eh, input logic [3:0] et,
                          input logic [7:0] ea, input logic [31:0] ex, input string req);
        lookup_addr = a;
        #1;
        checks++;
        if (dec_hit !== eh || dec_tgt !== et || dec_attr !== ea || dec_addr !== ex) begin
            failures++;
            $display("FAIL %s lookup %08h: got hit=%0b tgt=%0h attr=%02h addr=%08h expected hit=%0b tgt=%0h attr=%02h addr=%08h",
                     req, a, dec_hit, dec_tgt, dec_attr, dec_addr, eh, et, ea, ex);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_rd(7'h00, 32'h0, "R1");
        chk_rd(7'h04, 32'h0, "R1");
        chk_rd(7'h18, 32'h0, "R1");
        chk_lk(32'h0000_0000, 0, 0, 8'h00, 32'h0000_0000, "R1");

        // program windows
        wr(7'h00, 32'h000F_5141); wr(7'h04, 32'h9000_ABCD);
        wr(7'h08, 32'h4000_0000);
        wr(7'h10, 32'h00FF_5131); wr(7'h14, 32'h9800_0000);
        wr(7'h18, 32'h1200_5555); wr(7'h1C, 32'h0000_0001);
        wr(7'h20, 32'h0FFF_5941); wr(7'h24, 32'hE000_0000);
        wr(7'h28, 32'hDEAD_0000); wr(7'h2C, 32'hBEEF_0000);
        wr(7'h30, 32'h00FF_5931); wr(7'h34, 32'h9000_0000);
        wr(7'h40, 32'h0000_0F10); wr(7'h44, 32'hF000_0000);
        wr(7'h70, 32'h00FF_1E11); wr(7'h74, 32'hFF00_0000);

        // register readback
        chk_rd(7'h00, 32'h000F_5141, "R2");
        chk_rd(7'h07, 32'h9000_0000, "R2");
        chk_rd(7'h04, 32'h9000_0000, "R3");
        chk_rd(7'h18, 32'h1200_0000, "R3");
        chk_rd(7'h1C, 32'h0000_0001, "R11");
        chk_rd(7'h28, 32'h0000_0000, "R4");
        chk_rd(7'h2C, 32'h0000_0000, "R4");

        // vector table
        for (int i = 0; i < NV; i++)
            chk_lk(V_ADDR[i], V_HIT[i], V_TGT[i], V_ATTR[i], V_XLAT[i], V_REQ[i]);

        // R2: reserved control bits read zero; full-mask window catches everything
        wr(7'h50, 32'hFFFF_FFFF);
        chk_rd(7'h50, 32'hFFFF_FFF1, "R2");
        chk_lk(32'h0000_1000, 1, 4'hF, 8'hFF, 32'h0000_1000, "R7");
        chk_lk(32'h9001_2345, 1, 4'h4, 8'h51, 32'h4001_2345, "R7");
        wr(7'h50, 32'h0000_0000);
        chk_rd(7'h50, 32'h0000_0000, "R2");

        // R10: enabling window 4 only takes effect at the capturing edge
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 7'h40; reg_wdata = 32'h0000_0F11;
        chk_lk(32'hF000_0010, 0, 0, 8'h00, 32'hF000_0010, "R10");
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk_lk(32'hF000_0010, 1, 4'h1, 8'h0F, 32'hF000_0010, "R10");
        chk_lk(32'hF000_FFFF, 1, 4'h1, 8'h0F, 32'hF000_FFFF, "R5");
        chk_lk(32'hF001_0000, 0, 0, 8'h00, 32'hF001_0000, "R5");

        // R6: disable window 7
        wr(7'h70, 32'h00FF_1E10);
        chk_lk(32'hFF12_0004, 0, 0, 8'h00, 32'hFF12_0004, "R6");

        // R1: reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk_rd(7'h00, 32'h0, "R1");
        chk_rd(7'h1C, 32'h0, "R1");
        chk_lk(32'h9001_2345, 0, 0, 8'h00, 32'h9001_2345, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule